// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge and Completion Port

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best candidate: an ID, a priority value (numerically lower is more urgent) and a valid flag. The port decides whether that candidate may interrupt the processor. The candidate must clear a programmable priority mask. It must also be more urgent than the interrupt the processor is already servicing. The result is driven on a registered request line.

Software works through a small register window. Reading the acknowledge register claims the candidate: it returns the ID, records it as active, raises the running priority to its priority, and sends a one-cycle acknowledge back to the distributor, which clears the pending state of edge-triggered sources. When nothing qualifies, the read returns the spurious ID 1023 and nothing changes. Writing an ID to the completion register retires that active interrupt and forwards a one-cycle completion notice. Once the last active interrupt is retired, the running priority drops back to idle (all ones). Control, mask and binary-point registers can be read and written, so software can save and restore them.

Top module: `irq_cpu_port`

## Requirements
- R1: A read of register index 3 (acknowledge) while the candidate qualifies returns the candidate ID in bits 9:0 with bits 31:10 zero. On the same edge it stores the ID and priority in the active table and pulses `dist_ack` for one cycle with `dist_ack_id` equal to that ID.
- R2: An acknowledge read while no candidate qualifies returns 1023 (0x3FF). It leaves the active table untouched and does not pulse `dist_ack`.
- R3: Candidate IDs 1020 to 1023 never qualify: the request line stays low and an acknowledge returns 1023.
- R4: Writing an ID to register index 4 (completion) retires the active entry holding that ID and pulses `dist_eoi` with `dist_eoi_id` equal to it. A written ID that is not active changes nothing and gives no pulse.
- R5: A candidate qualifies only if its priority is strictly below the 8-bit mask held at register index 1; an equal value is blocked.
- R6: Bit 0 of register index 0 enables signalling. While it is 0 the request line stays low and an acknowledge returns 1023.
- R7: Register index 0 keeps bit 0, index 1 keeps bits 7:0 and index 2 keeps bits 2:0; all other bits read as zero, and all three reset to zero.
- R8: The running priority is the lowest priority value among active entries, or 0xFF with none active. A candidate qualifies only if its priority is strictly below the running priority.
- R9: `irq_o` is registered: it reflects the qualification of the inputs and state present at the previous rising edge.
- R10: With every active-table slot (NACT, default 4) occupied, no candidate qualifies: the request line stays low and an acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register index: 0 control, 1 mask, 2 binary point, 3 acknowledge, 4 completion |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq_o | output | 1 | Interrupt request to the processor |
| dist_ack | output | 1 | One-cycle pulse: candidate acknowledged |
| dist_ack_id | output | 10 | ID acknowledged |
| dist_eoi | output | 1 | One-cycle pulse: active interrupt completed |
| dist_eoi_id | output | 10 | ID completed |

## Verification
The bench probes each compare at its boundary. A priority equal to the mask must be blocked; a design using less-or-equal would raise the request line and hand out the ID. Nested service is checked by acknowledging an interrupt, confirming that a less urgent candidate is then held off, and confirming that the idle level of 0xFF is restored only after the last completion; a design that resets the running priority on the first completion, or never at all, shows the wrong request level. Reserved IDs, a full active table and a completion for an ID that is not active must each leave state unchanged and produce no pulse; a design that got these wrong would leak IDs 1020 to 1022, overwrite a slot, or send a stray completion.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_PMASK = 3'd1,
    RA_BPR   = 3'd2,
    RA_ACK   = 3'd3,
    RA_EOI   = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs #(
  parameter int PRIO_W = 8,
  parameter int BPR_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_pmask,
  input  logic              wr_bpr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_en,
  output logic [PRIO_W-1:0] pmask,
  output logic [BPR_W-1:0]  bpr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      pmask   <= '0;
      bpr     <= '0;
    end else begin
      if (wr_ctrl)  ctrl_en <= wdata[0];
      if (wr_pmask) pmask   <= wdata[PRIO_W-1:0];
      if (wr_bpr)   bpr     <= wdata[BPR_W-1:0];
    end
  end

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ctrl_en)) else $error("control changed without write"); // R7
endmodule

// File: rtl/cpuif_active_tbl.sv
module cpuif_active_tbl #(
  parameter int NACT   = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop_req,
  input  logic [ID_W-1:0]   pop_id,
  output logic              has_free,
  output logic              pop_hit,
  output logic [PRIO_W-1:0] run_prio
);
  localparam int IDX_W = (NACT > 1) ? $clog2(NACT) : 1;

  logic [NACT-1:0]   vld;
  logic [ID_W-1:0]   ids   [NACT];
  logic [PRIO_W-1:0] prios [NACT];
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  hit_idx;
  logic              hit_any;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    hit_any  = 1'b0;
    hit_idx  = '0;
    run_prio = '1;
    for (int i = NACT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (vld[i] && ids[i] == pop_id) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    for (int i = 0; i < NACT; i++) begin
      if (vld[i] && prios[i] < run_prio) run_prio = prios[i];
    end
  end

  assign pop_hit = pop_req && hit_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (push) begin
        vld[free_idx]   <= 1'b1;
        ids[free_idx]   <= push_id;
        prios[free_idx] <= push_prio;
      end
      if (pop_hit) vld[hit_idx] <= 1'b0;
    end
  end

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    push |-> has_free) else $error("push into full table"); // R10
  AST_RUN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !pop_hit |=> run_prio <= $past(run_prio)) else $error("running priority rose without completion"); // R8
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (pop_hit && !push && $countones(vld) == 1) |=> run_prio == '1) else $error("not idle after last completion"); // R8
endmodule

// File: rtl/cpuif_gate.sv
module cpuif_gate #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              has_free,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              qualify,
  output logic              irq_o
);
  localparam logic [ID_W-1:0] RSV_LO = ID_W'((1 << ID_W) - 4);

  assign qualify = ctrl_en && cand_valid && has_free &&
                   (cand_id < RSV_LO) &&
                   (cand_prio < pmask) &&
                   (cand_prio < run_prio);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= qualify;
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cand_prio >= pmask) |=> !irq_o) else $error("irq above mask"); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !irq_o) else $error("irq while disabled"); // R6
  AST_RSV_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cand_id >= RSV_LO) |=> !irq_o) else $error("irq for reserved id"); // R3
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int NACT   = 4,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int BPR_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              irq_o,
  output logic              dist_ack,
  output logic [ID_W-1:0]   dist_ack_id,
  output logic              dist_eoi,
  output logic [ID_W-1:0]   dist_eoi_id
);
  import irqc_pkg::*;

  localparam logic [ID_W-1:0] SPUR_ID = '1;
  localparam logic [ID_W-1:0] RSV_LO  = ID_W'((1 << ID_W) - 4);

  logic              ctrl_en;
  logic [PRIO_W-1:0] pmask;
  logic [BPR_W-1:0]  bpr;
  logic              has_free, pop_hit, qualify;
  logic [PRIO_W-1:0] run_prio;
  logic              ack_rd, push, eoi_wr;
  logic              wr_ctrl, wr_pmask, wr_bpr;

  assign wr_ctrl  = reg_wr && reg_addr == RA_CTRL;
  assign wr_pmask = reg_wr && reg_addr == RA_PMASK;
  assign wr_bpr   = reg_wr && reg_addr == RA_BPR;
  assign ack_rd   = reg_rd && reg_addr == RA_ACK;
  assign push     = ack_rd && qualify;
  assign eoi_wr   = reg_wr && !reg_rd && reg_addr == RA_EOI;

  cpuif_regs #(.PRIO_W(PRIO_W), .BPR_W(BPR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_pmask(wr_pmask), .wr_bpr(wr_bpr),
    .wdata(reg_wdata), .ctrl_en(ctrl_en), .pmask(pmask), .bpr(bpr)
  );

  cpuif_active_tbl #(.NACT(NACT), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_tbl (
    .clk(clk), .rst(rst), .push(push), .push_id(cand_id), .push_prio(cand_prio),
    .pop_req(eoi_wr), .pop_id(reg_wdata[ID_W-1:0]),
    .has_free(has_free), .pop_hit(pop_hit), .run_prio(run_prio)
  );

  cpuif_gate #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_gate (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .pmask(pmask), .run_prio(run_prio),
    .has_free(has_free), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .qualify(qualify), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata   <= '0;
      dist_ack    <= 1'b0;
      dist_ack_id <= '0;
      dist_eoi    <= 1'b0;
      dist_eoi_id <= '0;
    end else begin
      dist_ack <= push;
      dist_eoi <= pop_hit;
      if (push)    dist_ack_id <= cand_id;
      if (pop_hit) dist_eoi_id <= reg_wdata[ID_W-1:0];
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL:  reg_rdata <= DATA_W'(ctrl_en);
          RA_PMASK: reg_rdata <= DATA_W'(pmask);
          RA_BPR:   reg_rdata <= DATA_W'(bpr);
          RA_ACK:   reg_rdata <= DATA_W'(push ? cand_id : SPUR_ID);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  AST_ACK_NOT_RSV: assert property (@(posedge clk) disable iff (rst)
    dist_ack |-> dist_ack_id < RSV_LO) else $error("reserved id acknowledged"); // R3
  AST_SPUR_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !qualify) |=> !dist_ack) else $error("ack pulse on spurious read"); // R2
  AST_ACK_MATCHES_DATA: assert property (@(posedge clk) disable iff (rst)
    dist_ack |-> reg_rdata[ID_W-1:0] == dist_ack_id) else $error("ack id differs from read data"); // R1
  AST_EOI_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !eoi_wr |=> !dist_eoi) else $error("completion pulse without write"); // R4
endmodule

// File: tb/irq_cpu_port_test.sv
module irq_cpu_port_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cand_valid;
  logic [9:0]  cand_id;
  logic [7:0]  cand_prio;
  logic        irq_o, dist_ack, dist_eoi;
  logic [9:0]  dist_ack_id, dist_eoi_id;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_cpu_port uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cand_valid(cand_valid),
    .cand_id(cand_id), .cand_prio(cand_prio), .irq_o(irq_o), .dist_ack(dist_ack),
    .dist_ack_id(dist_ack_id), .dist_eoi(dist_eoi), .dist_eoi_id(dist_eoi_id)
  );

  typedef struct packed {
    logic       v;
    logic [9:0] id;
    logic [7:0] prio;
    logic [7:0] mask;
    logic       en;
    logic       irq;
    logic [9:0] ack;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'd40,   8'h80, 8'hF0, 1'b1, 1'b1, 10'd40},
    '{1'b1, 10'd41,   8'hF0, 8'hF0, 1'b1, 1'b0, 10'd1023},
    '{1'b1, 10'd42,   8'hEF, 8'hF0, 1'b1, 1'b1, 10'd42},
    '{1'b1, 10'd43,   8'h10, 8'hF0, 1'b0, 1'b0, 10'd1023},
    '{1'b0, 10'd44,   8'h10, 8'hF0, 1'b1, 1'b0, 10'd1023},
    '{1'b1, 10'd1020, 8'h10, 8'hF0, 1'b1, 1'b0, 10'd1023},
    '{1'b1, 10'd1019, 8'h10, 8'hF0, 1'b1, 1'b1, 10'd1019},
    '{1'b1, 10'd0,    8'h00, 8'h01, 1'b1, 1'b1, 10'd0},
    '{1'b1, 10'd5,    8'h00, 8'h00, 1'b1, 1'b0, 10'd1023},
    '{1'b1, 10'd1022, 8'h00, 8'hFF, 1'b1, 1'b0, 10'd1023}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output logic eoi, output logic [9:0] eid);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    eoi = dist_eoi; eid = dist_eoi_id;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic ack, output logic [9:0] aid);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; ack = dist_ack; aid = dist_ack_id;
  endtask

  task automatic set_cand(input logic v, input logic [9:0] id, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_prio = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic        f;
    logic [9:0]  i;
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    cand_valid = 1'b1; cand_id = 10'd7; cand_prio = 8'h10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R7 reset irq", 32'(irq_o), 32'd0);
    rd(3'd0, d, f, i); check("R7 reset ctrl", d, 32'd0);
    rd(3'd1, d, f, i); check("R7 reset mask", d, 32'd0);
    rd(3'd2, d, f, i); check("R7 reset bpr", d, 32'd0);
    rd(3'd3, d, f, i); check("R2 ack after reset", d, 32'd1023);
    check("R2 no ack pulse after reset", 32'(f), 32'd0);

    // register read/write and unused bits
    wr(3'd0, 32'hFFFF_FFFF, f, i); rd(3'd0, d, f, i); check("R7 ctrl bit0 only", d, 32'd1);
    wr(3'd1, 32'h1234_56A5, f, i); rd(3'd1, d, f, i); check("R7 mask 8 bits", d, 32'hA5);
    wr(3'd2, 32'hFFFF_FFFF, f, i); rd(3'd2, d, f, i); check("R7 bpr 3 bits", d, 32'd7);
    wr(3'd2, 32'd2, f, i);         rd(3'd2, d, f, i); check("R7 bpr rewrite", d, 32'd2);
    wr(3'd0, 32'd0, f, i);

    // vector walk
    for (int k = 0; k < NV; k++) begin
      wr(3'd0, 32'(VECS[k].en), f, i);
      wr(3'd1, 32'(VECS[k].mask), f, i);
      set_cand(VECS[k].v, VECS[k].id, VECS[k].prio);
      check($sformatf("R5/R6/R3 irq vec%0d", k), 32'(irq_o), 32'(VECS[k].irq));
      rd(3'd3, d, f, i);
      check($sformatf("R1/R2 ack data vec%0d", k), d, 32'(VECS[k].ack));
      check($sformatf("R1/R2 ack pulse vec%0d", k), 32'(f), 32'(VECS[k].ack != 10'd1023));
      if (VECS[k].ack != 10'd1023) begin
        check($sformatf("R1 ack id vec%0d", k), 32'(i), 32'(VECS[k].ack));
        wr(3'd4, 32'(VECS[k].ack), f, i);
        check($sformatf("R4 eoi pulse vec%0d", k), 32'(f), 32'd1);
        check($sformatf("R4 eoi id vec%0d", k), 32'(i), 32'(VECS[k].ack));
      end
      set_cand(1'b0, 10'd0, 8'hFF);
    end

    // registered irq timing
    wr(3'd0, 32'd1, f, i);
    wr(3'd1, 32'hFF, f, i);
    @(negedge clk);
    cand_valid = 1'b1; cand_id = 10'd70; cand_prio = 8'h20;
    #1 check("R9 irq not yet", 32'(irq_o), 32'd0);
    @(negedge clk);
    check("R9 irq one edge later", 32'(irq_o), 32'd1);
    set_cand(1'b0, 10'd0, 8'hFF);

    // running priority and nesting
    set_cand(1'b1, 10'd50, 8'h40);
    rd(3'd3, d, f, i); check("R1 ack 50", d, 32'd50);
    set_cand(1'b1, 10'd51, 8'h50);
    check("R8 less urgent held off", 32'(irq_o), 32'd0);
    rd(3'd3, d, f, i); check("R8 spurious while held", d, 32'd1023);
    set_cand(1'b1, 10'd52, 8'h40);
    check("R8 equal to running blocked", 32'(irq_o), 32'd0);
    set_cand(1'b1, 10'd52, 8'h30);
    check("R8 more urgent preempts", 32'(irq_o), 32'd1);
    rd(3'd3, d, f, i); check("R1 nested ack 52", d, 32'd52);
    wr(3'd4, 32'd99, f, i); check("R4 unknown id no pulse", 32'(f), 32'd0);
    set_cand(1'b1, 10'd51, 8'h38);
    check("R4 unknown eoi keeps running 0x30", 32'(irq_o), 32'd0);
    wr(3'd4, 32'd52, f, i); check("R4 eoi 52 pulse", 32'(f), 32'd1);
    set_cand(1'b1, 10'd51, 8'h50);
    check("R8 running back to 0x40", 32'(irq_o), 32'd0);
    wr(3'd4, 32'd50, f, i); check("R4 eoi 50 id", 32'(i), 32'd50);
    set_cand(1'b1, 10'd51, 8'hFE);
    check("R8 idle 0xFF after last eoi", 32'(irq_o), 32'd1);
    set_cand(1'b0, 10'd0, 8'hFF);

    // full active table
    for (int k = 0; k < 4; k++) begin
      set_cand(1'b1, 10'(60 + k), 8'(8'h40 - 8'h10 * k));
      rd(3'd3, d, f, i); check($sformatf("R10 fill slot %0d", k), d, 32'(60 + k));
    end
    set_cand(1'b1, 10'd64, 8'h05);
    check("R10 irq low when full", 32'(irq_o), 32'd0);
    rd(3'd3, d, f, i); check("R10 spurious when full", d, 32'd1023);
    check("R10 no ack pulse when full", 32'(f), 32'd0);
    for (int k = 3; k >= 0; k--) begin
      wr(3'd4, 32'(60 + k), f, i); check($sformatf("R4 drain %0d", k), 32'(f), 32'd1);
    end
    set_cand(1'b1, 10'd64, 8'h05);
    check("R10 irq after drain", 32'(irq_o), 32'd1);
    rd(3'd3, d, f, i); check("R1 ack 64 after drain", d, 32'd64);
    wr(3'd4, 32'd64, f, i);

    // disable mid-way
    wr(3'd0, 32'd0, f, i);
    set_cand(1'b1, 10'd80, 8'h01);
    check("R6 disabled irq low", 32'(irq_o), 32'd0);
    rd(3'd3, d, f, i); check("R6 disabled ack spurious", d, 32'd1023);

    summary();
  end
endmodule